// File: doc/BRIEF.md
# Flash Sector Precondition Sequencer

This block brings every word of one flash sector to all zeros before the sector is erased, so that no cell is driven into depletion by the erase. It steers a flash control block through a one-write-per-cycle register port with six targets: sector select, core enable, command, pump control, write address and write data. It also fetches words through a registered array read port. A single `start` pulse launches a run. The run enables the sector and the core, then walks the main array from `sec_first` to `sec_last` with row redundancy off. A second pass then covers the redundancy rows, `RED_WORDS` words indexed from `sec_first`.

Every word goes through a verify-then-pulse loop. The sequencer issues a verify command, fires the pump and reads the word. If the read is nonzero, it loads the write-data register with the inverse of that read, so only bits still at 1 are targeted. It then applies one timed program pulse and verifies again. Each word has a budget of `MAX_PULSES` pulses. Spending the last pulse of the budget aborts the run with an error. Whatever the outcome, the six control registers are cleared, the port returns to array mode, and `done` or `err` is raised.

Top module: `flash_precond_seq`

## Requirements
- R1: After `start`, the first write puts `sector_id` in the sector register (select code 0) and the second writes 1 to the enable register (code 1).
- R2: The command register (code 2) only ever receives 0x0000, the verify command (pass base XOR 0x0004) or the program command (pass base XOR 0x0003). The base is 0x0080 in the main pass and 0x0100 in the redundancy pass.
- R3: Each pump-on write (code 3, value 0x0005) follows its command write by the verify setup time + 1 cycles, or by the program setup time + 1 cycles. A program pump-off write follows its pump-on write by `T_PROG` + 1 cycles. The pump register only ever receives 0x0000 or 0x0005.
- R4: A word whose verify read is 0x0000 gets no pulse. Otherwise the write-data register (code 5) is loaded with the bitwise inverse of the read before the pulse.
- R5: On a successful run, every main word and every redundancy word reads zero, and `done` rises with `err` low.
- R6: If a word is still nonzero when its `MAX_PULSES`-th pulse has been applied, the run ends with `err` high, and no later word is verified or programmed. A word that needs `MAX_PULSES`-1 pulses completes normally.
- R7: `pulse_cnt` is cleared by `start` and rises by exactly one for every applied program pulse.
- R8: Every run ends with six writes of zero, to pump (3), command (2), address (4), data (5), enable (1) and sector (0) in that order. After that, `reg_mode` is low.
- R9: `done` and `err` are never high together. Each stays high until the next `start`.
- R10: `arr_rd` is only asserted while `reg_mode` is low (array mode).
- R11: Out of reset, `done`, `err`, `busy`, `reg_we`, `arr_rd` and `pulse_cnt` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a run (ignored while busy) |
| sector_id | input | SEC_W | Value written to the sector register |
| sec_first | input | AW | First word address of the sector |
| sec_last | input | AW | Last word address of the main pass |
| reg_we | output | 1 | Register write strobe |
| reg_sel | output | 3 | Register select code |
| reg_wdata | output | 16 | Register write value |
| arr_rd | output | 1 | Array read strobe, data expected the next cycle |
| arr_addr | output | AW | Array read address |
| arr_rdata | input | 16 | Array read data |
| reg_mode | output | 1 | High while the flash is in register access mode |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished cleanly (sticky) |
| err | output | 1 | Run aborted on pulse budget (sticky) |
| pulse_cnt | output | PC_W | Pulses applied in this run |

## Verification
Read data is due one cycle after the `arr_rd` strobe. The bench's flash model drives it on the falling edge inside the strobe cycle, so it is stable at the capturing edge. Each pump-on write is due exactly setup + 1 cycles after its command write, and the program pump-off write exactly `T_PROG` + 1 cycles after pump-on. The model timestamps every strobe on the falling edge and compares the exact distances, not lower bounds. `done` and `err` rise one cycle after the sixth clearing write. The bench waits for either flag, samples all results on a falling edge, and only then compares the pulse count and the memory contents.

// File: rtl/fps_pkg.sv
package fps_pkg;
  typedef enum logic [2:0] {
    SEL_SECTOR = 3'd0,
    SEL_ENABLE = 3'd1,
    SEL_CTRL   = 3'd2,
    SEL_PUMP   = 3'd3,
    SEL_WADDR  = 3'd4,
    SEL_WDATA  = 3'd5
  } reg_sel_e;

  localparam logic [15:0] BASE_MAIN = 16'h0080;
  localparam logic [15:0] BASE_RED  = 16'h0100;
  localparam logic [15:0] VFY_XOR   = 16'h0004;
  localparam logic [15:0] PRG_XOR   = 16'h0003;
  localparam logic [15:0] PUMP_ON   = 16'h0005;

  typedef enum logic [4:0] {
    ST_IDLE, ST_EN_SECT, ST_EN_CORE,
    ST_V_ADDR, ST_V_CTRL, ST_V_SETUP, ST_V_PUMP, ST_V_ACC,
    ST_V_READ, ST_V_CAPT, ST_V_CLRP, ST_V_CLRC, ST_V_DECIDE,
    ST_P_DATA, ST_P_CTRL, ST_P_SETUP, ST_P_PUMP, ST_P_PULSE,
    ST_P_OFF, ST_P_HOLD, ST_P_CLRP, ST_P_CLRC, ST_P_COUNT,
    ST_W_NEXT, ST_FIN
  } st_e;
endpackage

// File: rtl/fps_wait_timer.sv
module fps_wait_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)             cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/fps_word_cursor.sv
module fps_word_cursor #(
  parameter int AW         = 8,
  parameter int MAX_PULSES = 8,
  localparam int BW        = $clog2(MAX_PULSES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic [AW-1:0] init_addr,
  input  logic          step,
  input  logic          spend,
  output logic [AW-1:0] addr,
  output logic          last_pulse
);
  logic [AW-1:0] addr_q, addr_d;
  logic [BW-1:0] bud_q, bud_d;
  logic          addr_en, bud_en;

  assign addr_en = init | step;
  assign bud_en  = init | step | spend;

  always_comb begin
    addr_d = init ? init_addr : addr_q + 1'b1;
    bud_d  = (init | step) ? BW'(MAX_PULSES) : bud_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      bud_q  <= '0;
    end else begin
      if (addr_en) addr_q <= addr_d;
      if (bud_en)  bud_q  <= bud_d;
    end
  end

  assign addr       = addr_q;
  assign last_pulse = (bud_q == BW'(1));
endmodule

// File: rtl/flash_precond_seq.sv
module flash_precond_seq
  import fps_pkg::*;
#(
  parameter int AW         = 8,
  parameter int SEC_W      = 4,
  parameter int RED_WORDS  = 32,
  parameter int MAX_PULSES = 8,
  parameter int PC_W       = 16,
  parameter int T_PVSU     = 4,
  parameter int T_PVA      = 3,
  parameter int T_PSU      = 5,
  parameter int T_PROG     = 10,
  parameter int T_PH       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SEC_W-1:0] sector_id,
  input  logic [AW-1:0]    sec_first,
  input  logic [AW-1:0]    sec_last,
  output logic             reg_we,
  output logic [2:0]       reg_sel,
  output logic [15:0]      reg_wdata,
  output logic             arr_rd,
  output logic [AW-1:0]    arr_addr,
  input  logic [15:0]      arr_rdata,
  output logic             reg_mode,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [PC_W-1:0]  pulse_cnt
);
  localparam int TW = $clog2(T_PVSU + T_PVA + T_PSU + T_PROG + T_PH + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  st_e            st_q, st_d;
  logic           pass_q, fail_q, done_q, err_q;
  logic [AW-1:0]  last_q;
  logic [2:0]     clr_q;
  logic [15:0]    rd_q;
  logic [PC_W-1:0] pc_q;

  logic           t_load, t_exp;
  logic [TW-1:0]  t_val;
  logic           cur_init, cur_step, cur_spend, cur_last;
  logic [AW-1:0]  cur_addr, init_addr;
  logic           at_end, go, pass_sw;
  logic [15:0]    base;

  assign go       = (st_q == ST_IDLE) && start;
  assign at_end   = (cur_addr == last_q);
  assign pass_sw  = (st_q == ST_W_NEXT) && at_end && !pass_q;
  assign cur_init = go || pass_sw;
  assign cur_step = (st_q == ST_W_NEXT) && !at_end;
  assign cur_spend = (st_q == ST_P_COUNT);
  assign init_addr = sec_first;
  assign base     = pass_q ? BASE_RED : BASE_MAIN;

  fps_wait_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_ni), .load(t_load), .load_val(t_val), .expired(t_exp)
  );

  fps_word_cursor #(.AW(AW), .MAX_PULSES(MAX_PULSES)) u_cursor (
    .clk(clk), .rst_n(rst_ni), .init(cur_init), .init_addr(init_addr),
    .step(cur_step), .spend(cur_spend), .addr(cur_addr), .last_pulse(cur_last)
  );

  // next-state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:     if (start) st_d = ST_EN_SECT;
      ST_EN_SECT:  st_d = ST_EN_CORE;
      ST_EN_CORE:  st_d = ST_V_ADDR;
      ST_V_ADDR:   st_d = ST_V_CTRL;
      ST_V_CTRL:   st_d = ST_V_SETUP;
      ST_V_SETUP:  if (t_exp) st_d = ST_V_PUMP;
      ST_V_PUMP:   st_d = ST_V_ACC;
      ST_V_ACC:    if (t_exp) st_d = ST_V_READ;
      ST_V_READ:   st_d = ST_V_CAPT;
      ST_V_CAPT:   st_d = ST_V_CLRP;
      ST_V_CLRP:   st_d = ST_V_CLRC;
      ST_V_CLRC:   st_d = ST_V_DECIDE;
      ST_V_DECIDE: st_d = (rd_q == 16'h0000) ? ST_W_NEXT : ST_P_DATA;
      ST_P_DATA:   st_d = ST_P_CTRL;
      ST_P_CTRL:   st_d = ST_P_SETUP;
      ST_P_SETUP:  if (t_exp) st_d = ST_P_PUMP;
      ST_P_PUMP:   st_d = ST_P_PULSE;
      ST_P_PULSE:  if (t_exp) st_d = ST_P_OFF;
      ST_P_OFF:    st_d = ST_P_HOLD;
      ST_P_HOLD:   if (t_exp) st_d = ST_P_CLRP;
      ST_P_CLRP:   st_d = ST_P_CLRC;
      ST_P_CLRC:   st_d = ST_P_COUNT;
      ST_P_COUNT:  st_d = cur_last ? ST_FIN : ST_V_ADDR;
      ST_W_NEXT:   st_d = (at_end && pass_q) ? ST_FIN : ST_V_ADDR;
      ST_FIN:      if (clr_q == 3'd5) st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
  end

  // wait loads
  always_comb begin
    t_load = 1'b1;
    t_val  = '0;
    unique case (st_q)
      ST_V_CTRL: t_val = TW'(T_PVSU - 1);
      ST_V_PUMP: t_val = TW'(T_PVA - 1);
      ST_P_CTRL: t_val = TW'(T_PSU - 1);
      ST_P_PUMP: t_val = TW'(T_PROG - 1);
      ST_P_OFF:  t_val = TW'(T_PH - 1);
      default:   t_load = 1'b0;
    endcase
  end

  // register port
  always_comb begin
    reg_we    = 1'b1;
    reg_sel   = SEL_PUMP;
    reg_wdata = 16'h0000;
    unique case (st_q)
      ST_EN_SECT: begin reg_sel = SEL_SECTOR; reg_wdata = 16'(sector_id); end
      ST_EN_CORE: begin reg_sel = SEL_ENABLE; reg_wdata = 16'h0001; end
      ST_V_ADDR:  begin reg_sel = SEL_WADDR;  reg_wdata = 16'(cur_addr); end
      ST_V_CTRL:  begin reg_sel = SEL_CTRL;   reg_wdata = base ^ VFY_XOR; end
      ST_V_PUMP, ST_P_PUMP: reg_wdata = PUMP_ON;
      ST_V_CLRP, ST_P_CLRP, ST_P_OFF: reg_sel = SEL_PUMP;
      ST_V_CLRC, ST_P_CLRC: reg_sel = SEL_CTRL;
      ST_P_DATA:  begin reg_sel = SEL_WDATA;  reg_wdata = ~rd_q; end
      ST_P_CTRL:  begin reg_sel = SEL_CTRL;   reg_wdata = base ^ PRG_XOR; end
      ST_FIN: begin
        unique case (clr_q)
          3'd0:    reg_sel = SEL_PUMP;
          3'd1:    reg_sel = SEL_CTRL;
          3'd2:    reg_sel = SEL_WADDR;
          3'd3:    reg_sel = SEL_WDATA;
          3'd4:    reg_sel = SEL_ENABLE;
          default: reg_sel = SEL_SECTOR;
        endcase
      end
      default: reg_we = 1'b0;
    endcase
  end

  // state and bookkeeping registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pass_q <= 1'b0;
      fail_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      last_q <= '0;
      clr_q  <= '0;
      rd_q   <= '0;
      pc_q   <= '0;
    end else begin
      st_q <= st_d;
      if (go) begin
        pass_q <= 1'b0;
        fail_q <= 1'b0;
        done_q <= 1'b0;
        err_q  <= 1'b0;
        last_q <= sec_last;
        pc_q   <= '0;
      end
      if (pass_sw) begin
        pass_q <= 1'b1;
        last_q <= sec_first + AW'(RED_WORDS - 1);
      end
      if (st_q == ST_V_CAPT) rd_q <= arr_rdata;
      if (cur_spend) begin
        pc_q <= pc_q + 1'b1;
        if (cur_last) fail_q <= 1'b1;
      end
      if (st_q == ST_FIN) begin
        clr_q <= clr_q + 1'b1;
        if (clr_q == 3'd5) begin
          done_q <= !fail_q;
          err_q  <= fail_q;
        end
      end else begin
        clr_q <= '0;
      end
    end
  end

  assign arr_rd    = (st_q == ST_V_READ);
  assign arr_addr  = cur_addr;
  assign reg_mode  = (st_q != ST_IDLE) && (st_q != ST_V_READ);
  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign pulse_cnt = pc_q;
endmodule

// File: rtl/flash_precond_chk.sv
module flash_precond_chk #(
  parameter int PC_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            reg_we,
  input logic [2:0]      reg_sel,
  input logic [15:0]     reg_wdata,
  input logic            arr_rd,
  input logic            reg_mode,
  input logic            busy,
  input logic            done,
  input logic            err,
  input logic [PC_W-1:0] pulse_cnt
);
  // R9
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> err);

  // R8
  final_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) || $rose(err)) |->
      ($past(reg_we) && $past(reg_sel) == 3'd0 && $past(reg_wdata) == 16'h0000));

  // R7
  pulse_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_cnt != $past(pulse_cnt)) |->
      ((pulse_cnt == $past(pulse_cnt) + 1'b1) || (pulse_cnt == '0)));

  // R10
  read_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd |-> !reg_mode);

  // R3
  pump_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == 3'd3) |-> (reg_wdata == 16'h0000 || reg_wdata == 16'h0005));

  // R1
  write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> busy);
endmodule

bind flash_precond_seq flash_precond_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .reg_we(reg_we), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .arr_rd(arr_rd), .reg_mode(reg_mode), .busy(busy),
  .done(done), .err(err), .pulse_cnt(pulse_cnt)
);

// File: tb/tb_flash_precond_seq.sv
`timescale 1ns/1ps
module tb_flash_precond_seq;
  localparam int AW = 8, SW = 4, RED = 32, MAXP = 8, PCW = 16;
  localparam int TPVSU = 4, TPVA = 3, TPSU = 5, TPROG = 10, TPH = 2;

  logic clk = 1'b0;
  logic rst_n, start;
  logic [SW-1:0] sector_id;
  logic [AW-1:0] sec_first, sec_last;
  logic reg_we, arr_rd, reg_mode, busy, done, err;
  logic [2:0] reg_sel;
  logic [15:0] reg_wdata, arr_rdata;
  logic [AW-1:0] arr_addr;
  logic [PCW-1:0] pulse_cnt;

  flash_precond_seq #(.AW(AW), .SEC_W(SW), .RED_WORDS(RED), .MAX_PULSES(MAXP), .PC_W(PCW),
    .T_PVSU(TPVSU), .T_PVA(TPVA), .T_PSU(TPSU), .T_PROG(TPROG), .T_PH(TPH)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sector_id(sector_id), .sec_first(sec_first),
    .sec_last(sec_last), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .arr_rd(arr_rd), .arr_addr(arr_addr), .arr_rdata(arr_rdata), .reg_mode(reg_mode),
    .busy(busy), .done(done), .err(err), .pulse_cnt(pulse_cnt));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  logic [15:0] mainm [256];
  logic [15:0] redm [RED];
  logic [15:0] ctrl_r, wdata_r, last_rd;
  logic [AW-1:0] waddr_r;
  logic [18:0] wlog [6];
  logic [18:0] w0, w1;
  int cyc = 0, ctrl_cyc = 0, on_cyc = 0, nwr = 0, npulses = 0;
  int bad_cmd = 0, bad_time = 0, bad_data = 0, bad_mode = 0, stuck = -1;
  bit pulsing = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic program_word(input bit red_sel);
    logic [15:0] cur, t;
    int idx;
    idx = red_sel ? int'(waddr_r) - int'(sec_first) : int'(waddr_r);
    if (!red_sel && idx == stuck) return;
    cur = red_sel ? redm[idx] : mainm[idx];
    t = cur & ~wdata_r;
    cur = cur & ~(t & (~t + 16'd1));
    if (red_sel) redm[idx] = cur; else mainm[idx] = cur;
  endtask

  // flash model, sampled away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (arr_rd) begin
      if (reg_mode) bad_mode++;
      if (ctrl_r == 16'h0084)      arr_rdata = mainm[arr_addr];
      else if (ctrl_r == 16'h0104) arr_rdata = redm[int'(arr_addr) - int'(sec_first)];
      else                         arr_rdata = 16'hDEAD;
      last_rd = arr_rdata;
    end
    if (reg_we) begin
      for (int i = 0; i < 5; i++) wlog[i] = wlog[i+1];
      wlog[5] = {reg_sel, reg_wdata};
      nwr++;
      if (nwr == 1) w0 = {reg_sel, reg_wdata};
      if (nwr == 2) w1 = {reg_sel, reg_wdata};
      case (reg_sel)
        3'd2: begin
          ctrl_r = reg_wdata; ctrl_cyc = cyc;
          if (!(reg_wdata inside {16'h0000, 16'h0084, 16'h0083, 16'h0104, 16'h0103})) bad_cmd++;
        end
        3'd3: begin
          if (reg_wdata == 16'h0005) begin
            if (ctrl_r == 16'h0084 || ctrl_r == 16'h0104) begin
              if (cyc - ctrl_cyc != TPVSU + 1) bad_time++;
            end else if (ctrl_r == 16'h0083 || ctrl_r == 16'h0103) begin
              if (cyc - ctrl_cyc != TPSU + 1) bad_time++;
              if (wdata_r != ~last_rd) bad_data++;
              on_cyc = cyc; pulsing = 1; npulses++;
              program_word(ctrl_r == 16'h0103);
            end else bad_cmd++;
          end else if (pulsing) begin
            if (cyc - on_cyc != TPROG + 1) bad_time++;
            pulsing = 0;
          end
        end
        3'd4: waddr_r = reg_wdata[AW-1:0];
        3'd5: wdata_r = reg_wdata;
        default: ;
      endcase
    end
  end

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mainm[i] = 16'h0000;
    for (int i = 0; i < RED; i++) redm[i] = 16'h0000;
    stuck = -1;
  endtask

  task automatic run(input logic [SW-1:0] sid);
    int t;
    @(negedge clk);
    nwr = 0; npulses = 0; bad_cmd = 0; bad_time = 0; bad_data = 0; bad_mode = 0;
    ctrl_r = 16'h0000; pulsing = 0;
    sector_id = sid; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!(done || err) && t < 20000) begin @(negedge clk); t++; end
    chk(t < 20000, "R5", "run finished", t, 0);
  endtask

  task automatic check_common(input logic [SW-1:0] sid);
    logic [2:0] order [6] = '{3'd3, 3'd2, 3'd4, 3'd5, 3'd1, 3'd0};
    chk(w0 == {3'd0, 16'(sid)}, "R1", "first write", w0, {3'd0, 16'(sid)});
    chk(w1 == {3'd1, 16'h0001}, "R1", "second write", w1, {3'd1, 16'h0001});
    chk(bad_cmd == 0, "R2", "bad commands", bad_cmd, 0);
    chk(bad_time == 0, "R3", "timing violations", bad_time, 0);
    chk(bad_data == 0, "R4", "data not inverse of read", bad_data, 0);
    chk(bad_mode == 0, "R10", "read in register mode", bad_mode, 0);
    for (int i = 0; i < 6; i++)
      chk(wlog[i] == {order[i], 16'h0000}, "R8", "clear write", wlog[i], {order[i], 16'h0000});
    chk(!reg_mode && !busy, "R8", "back to array mode", {reg_mode, busy}, 0);
    chk(!(done && err), "R9", "done/err exclusive", {done, err}, 2'b10);
  endtask

  task automatic check_clean(input int exp_p);
    int nz = 0;
    for (int i = int'(sec_first); i <= int'(sec_last); i++) if (mainm[i] != 0) nz++;
    for (int i = 0; i < RED; i++) if (redm[i] != 0) nz++;
    chk(done && !err, "R5", "done flag", {done, err}, 2'b10);
    chk(nz == 0, "R5", "nonzero words left", nz, 0);
    chk(pulse_cnt == PCW'(exp_p), "R7", "pulse count", pulse_cnt, exp_p);
    chk(npulses == exp_p, "R4", "pulses applied", npulses, exp_p);
  endtask

  task automatic test_reset();
    chk(!done && !err && !busy && !reg_we && !arr_rd && pulse_cnt == 0, "R11", "reset outputs",
        {done, err, busy, reg_we, arr_rd, pulse_cnt}, 0);
  endtask

  task automatic test_blank();
    clear_mem();
    run(4'h3);
    check_common(4'h3);
    check_clean(0);
  endtask

  task automatic test_mixed();
    int exp_p = 0;
    clear_mem();
    for (int i = int'(sec_first); i <= int'(sec_last); i++) begin
      mainm[i] = 16'(1 << (i % 16)) | ((i % 3 == 0) ? 16'h8000 : 16'h0000);
      exp_p += $countones(mainm[i]);
    end
    for (int i = 0; i < RED; i += 5) begin redm[i] = 16'h0F00; exp_p += 4; end
    run(4'h9);
    check_common(4'h9);
    check_clean(exp_p);
  endtask

  task automatic test_boundary();
    clear_mem();
    mainm[sec_last] = 16'h007F;
    redm[0] = 16'h0001;
    redm[RED-1] = 16'h8000;
    run(4'hA);
    check_common(4'hA);
    check_clean(MAXP - 1 + 2);
  endtask

  task automatic test_stuck();
    clear_mem();
    mainm[sec_first + 1] = 16'h0003;
    mainm[sec_first + 3] = 16'h0010;
    stuck = int'(sec_first) + 3;
    mainm[sec_last] = 16'h00FF;
    redm[2] = 16'h0001;
    run(4'h5);
    check_common(4'h5);
    chk(err && !done, "R6", "error flag", {done, err}, 2'b01);
    chk(pulse_cnt == PCW'(2 + MAXP), "R6", "pulses at abort", pulse_cnt, 2 + MAXP);
    chk(mainm[sec_last] == 16'h00FF, "R6", "later word untouched", mainm[sec_last], 16'h00FF);
    chk(redm[2] == 16'h0001, "R6", "redundancy untouched", redm[2], 16'h0001);
    chk(mainm[sec_first + 1] == 0, "R6", "earlier word cleared", mainm[sec_first + 1], 0);
  endtask

  task automatic test_sticky();
    repeat (40) @(negedge clk);
    chk(err && !done, "R9", "error held", {done, err}, 2'b01);
    clear_mem();
    run(4'h1);
    chk(done && !err, "R9", "start clears error", {done, err}, 2'b10);
    chk(pulse_cnt == 0, "R7", "count cleared by start", pulse_cnt, 0);
    repeat (40) @(negedge clk);
    chk(done && !err, "R9", "done held", {done, err}, 2'b10);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; sector_id = '0;
    sec_first = 8'd16; sec_last = 8'd31; arr_rdata = 16'h0000;
    ctrl_r = 16'h0000; wdata_r = 16'h0000; last_rd = 16'h0000; waddr_r = '0;
    for (int i = 0; i < 6; i++) wlog[i] = '1;
    w0 = '1; w1 = '1;
    clear_mem();
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset();
    test_blank();
    test_mixed();
    test_boundary();
    test_stuck();
    test_sticky();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule